// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block models a clocked static RAM whose reads are flow-through: the address is captured on a rising clock edge, and the stored word appears on the read bus in the same cycle, with no output register. Two address strobes can start an access. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write qualifiers.

After a burst has started, an advance input steps a 2-bit burst counter through the four words of an aligned group. A strap selects linear or interleaved ordering. Holding advance off suspends the burst, which gives the attached master a wait state.

Writes are masked per byte lane, and each lane carries its own parity bit. A global write overrides the per-lane enables. Three chip enables qualify every new access. An output enable and a sleep input gate the data bus without waiting for the clock.

Top module: `sburst_sram`

## Requirements
- R1: A cycle writes when `gw_n` is 0, or when `bwe_n` is 0 and at least one bit of `bw_n` is 0. With `gw_n`, `bwe_n` and all of `bw_n` at 1, the cycle is a read.
- R2: When `adsp_n` and `ce_n` are both 0 at an edge with the chip selected, a read burst starts at `addr`, and the write inputs have no effect on the array.
- R3: When `adsc_n` is 0 at an edge with the chip selected and no processor start, `addr` is loaded. The cycle writes `dq_i` to that address or reads from it, as R1 decides.
- R4: Lane i covers `dq_i`/`dq_o` bits [9i+8:9i], parity in bit 9i+8. During a write it is updated when `gw_n` is 0 or `bw_n[i]` is 0, and it is left unchanged otherwise.
- R5: A strobe at an edge where `ce_n`=0, `ce2`=1 and `ce2_n`=0 do not all hold is a deselect. It loads no address and writes nothing, and `dq_oe` is 0 afterwards.
- R6: `adsp_n` at 0 while `ce_n` is 1 is ignored, and the cycle acts as a continue cycle.
- R7: In a continue cycle with `adv_n`=0, the 2-bit counter k steps by one and wraps after four beats. The low address bits are (start+k) mod 4 when `lin_order`=1, and start XOR k when `lin_order`=0.
- R8: In a continue cycle with `adv_n`=1, the current address is reused for the read or write.
- R9: `dq_o` shows the word at the registered burst address in the same cycle as the edge that set that address.
- R10: `dq_oe` is 1 only while a read burst is active, `oe_n` is 0 and `zz` is 0. `oe_n` acts without a clock.
- R11: While `zz` is 1, `dq_oe` is 0 at once, the clocked inputs are ignored, no write happens and the burst state is held.
- R12: After reset, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Power-on reset, active low |
| zz | input | 1 | Snooze, active high |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe |
| adsc_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write |
| bwe_n | input | 1 | Byte write qualifier |
| bw_n | input | LANES | Per-lane write enables |
| oe_n | input | 1 | Output enable, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | Word address |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Read bus drive enable |

## Verification
The whole array is first filled with single controller-strobe writes, each word a distinct arithmetic hash of its address. Every start offset in every 4-word group is then read back as a burst in both orderings, so a wrong step, a wrong wrap or a swapped ordering shows up as the wrong hash. Burst writes in alternating orders are then read back with single processor strobes, which tells counter errors on the write path apart from those on the read path. Directed sequences then drive each edge case: strobe precedence, lane masks with and without the global override, suspend, deselect, ignored strobes, and snooze or output-enable while a read is in progress.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      zz,
  input  logic                      ce_n,
  input  logic                      ce2,
  input  logic                      ce2_n,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic                      lin_order,
  input  logic [AW-1:0]             addr,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic                      dq_oe
);
  localparam int DEPTH = 1 << AW;

  logic            act_q, rd_q, act_d, rd_d, we;
  logic [AW-3:0]   base_q, base_d;
  logic [1:0]      st_q, st_d, cnt_q, cnt_d;
  logic [AW-1:0]   ra, wa;

  wire sel     = !ce_n && ce2 && !ce2_n;
  wire p_start = !adsp_n && !ce_n;
  wire c_start = !p_start && !adsc_n;
  wire start   = p_start || c_start;
  wire is_wr   = !gw_n || (!bwe_n && !(&bw_n));

  function automatic logic [1:0] lo(input logic [1:0] s, input logic [1:0] k, input logic lin);
    return lin ? s + k : s ^ k;
  endfunction

  always_comb begin
    act_d  = act_q;
    rd_d   = rd_q;
    base_d = base_q;
    st_d   = st_q;
    cnt_d  = cnt_q;
    we     = 1'b0;
    if (start) begin
      if (sel) begin
        act_d  = 1'b1;
        base_d = addr[AW-1:2];
        st_d   = addr[1:0];
        cnt_d  = 2'd0;
        rd_d   = p_start || !is_wr;
        we     = c_start && is_wr;
      end else begin
        act_d = 1'b0;
        rd_d  = 1'b0;
      end
    end else if (act_q) begin
      if (!adv_n) cnt_d = cnt_q + 2'd1;
      rd_d = !is_wr;
      we   = is_wr;
    end
  end

  assign ra = {base_q, lo(st_q, cnt_q, lin_order)};
  assign wa = {base_d, lo(st_d, cnt_d, lin_order)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      st_q   <= '0;
      cnt_q  <= '0;
    end else if (!zz) begin
      act_q  <= act_d;
      rd_q   <= rd_d;
      base_q <= base_d;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    wire lane_en = !gw_n || !bw_n[i];
    always_ff @(posedge clk)
      if (rst_n && !zz && we && lane_en) mem[wa] <= dq_i[i*LANE_W +: LANE_W];
    assign dq_o[i*LANE_W +: LANE_W] = mem[ra];
  end

  assign dq_oe = act_q && rd_q && !oe_n && !zz;

  // R12
  a_r12_reset_idle: assert property (@(posedge clk) !rst_n |=> !act_q && !dq_oe);
  // R2
  a_r2_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && p_start && sel) |=> (rd_q && act_q));
  // R5
  a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && start && !sel) |=> (!act_q && !dq_oe));
  // R8
  a_r8_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !start && act_q && adv_n) |=> ($stable(cnt_q) && $stable(base_q) && $stable(st_q)));
  // R7
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !start && act_q && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));
  // R11
  a_r11_snooze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ($stable(cnt_q) && $stable(act_q) && $stable(rd_q) && $stable(base_q)));
endmodule

// File: tb/sburst_sram_tb.sv
`timescale 1ns/1ps
module sburst_sram_tb;
  logic clk = 0, rst_n = 0, zz = 0, ce_n = 0, ce2 = 1, ce2_n = 0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, gw_n = 1, bwe_n = 1, oe_n = 0, lin_order = 1;
  logic [1:0]  bw_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] dq_i = '0;
  logic [17:0] dq_o;
  logic        dq_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sburst_sram u_dut (.clk, .rst_n, .zz, .ce_n, .ce2, .ce2_n, .adsp_n, .adsc_n, .adv_n,
    .gw_n, .bwe_n, .bw_n, .oe_n, .lin_order, .addr, .dq_i, .dq_o, .dq_oe);

  function automatic logic [17:0] h(int a, int salt);
    return 18'((a * 2731 + salt * 40503 + 17) % 262144);
  endfunction

  function automatic int ex(int base, int s, int k, int lin);
    return base * 4 + (lin != 0 ? (s + k) % 4 : (s ^ (k % 4)));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic p, logic c, logic v, logic g, logic be, logic [1:0] bw,
                      logic [5:0] a, logic [17:0] d);
    adsp_n = p; adsc_n = c; adv_n = v; gw_n = g; bwe_n = be; bw_n = bw; addr = a; dq_i = d;
    @(posedge clk); #1;
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
  endtask

  task automatic rd1(string tag, int a, logic [17:0] exp);
    step(0, 1, 1, 1, 1, 2'b11, 6'(a), '0);
    chk(tag, dq_oe, 1);
    chk(tag, dq_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset bus off", dq_oe, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R12 after reset", dq_oe, 0);

    for (int a = 0; a < 64; a++) step(1, 0, 1, 0, 1, 2'b11, 6'(a), h(a, 0));
    chk("R3 write cycle bus off", dq_oe, 0);

    for (int m = 0; m < 2; m++) begin
      lin_order = m[0];
      for (int b = 0; b < 16; b++)
        for (int s = 0; s < 4; s++) begin
          step(0, 1, 1, 1, 1, 2'b11, 6'(b * 4 + s), '0);
          chk("R9 R2 burst beat0", dq_o, h(ex(b, s, 0, m), 0));
          for (int k = 1; k < 5; k++) begin
            step(1, 1, 0, 1, 1, 2'b11, '0, '0);
            chk("R7 burst order", dq_o, h(ex(b, s, k, m), 0));
          end
          chk("R10 read drive", dq_oe, 1);
        end
    end

    for (int b = 0; b < 16; b++) begin
      int m = b % 2, s = (b / 2) % 4;
      lin_order = m[0];
      step(1, 0, 1, 0, 1, 2'b11, 6'(b * 4 + s), h(ex(b, s, 0, m), 1));
      for (int k = 1; k < 4; k++) step(1, 1, 0, 1, 0, 2'b00, '0, h(ex(b, s, k, m), 1));
    end
    lin_order = 1;
    for (int a = 0; a < 64; a++) rd1("R7 R3 burst write", a, h(a, 1));

    step(0, 1, 1, 0, 0, 2'b00, 6'd5, 18'h0);
    chk("R2 adsp ignores write", dq_o, h(5, 1));
    chk("R2 adsp drives bus", dq_oe, 1);
    rd1("R2 array unchanged", 5, h(5, 1));

    step(1, 0, 1, 1, 0, 2'b10, 6'd6, 18'h3FFFF);
    rd1("R4 lane0 only", 6, {h(6, 1)[17:9], 9'h1FF});
    step(1, 0, 1, 1, 0, 2'b01, 6'd6, 18'h0);
    rd1("R4 lane1 only", 6, {9'h000, 9'h1FF});

    step(1, 0, 1, 1, 1, 2'b00, 6'd7, 18'h0);
    chk("R1 bwe high is read", dq_oe, 1);
    chk("R1 bwe high data", dq_o, h(7, 1));
    step(1, 0, 1, 0, 1, 2'b11, 6'd7, 18'h2A5A5);
    rd1("R1 R4 global write all lanes", 7, 18'h2A5A5);

    step(0, 1, 1, 1, 1, 2'b11, 6'd8, '0);
    step(1, 1, 1, 1, 1, 2'b11, '0, '0);
    chk("R8 suspend holds", dq_o, h(8, 1));
    step(1, 1, 0, 1, 1, 2'b11, '0, '0);
    chk("R7 advance after suspend", dq_o, h(9, 1));

    ce_n = 1;
    step(0, 1, 1, 1, 1, 2'b11, 6'd40, '0);
    chk("R6 ignored adsp data", dq_o, h(9, 1));
    chk("R6 ignored adsp bus", dq_oe, 1);
    step(0, 1, 0, 1, 1, 2'b11, 6'd40, '0);
    chk("R6 ignored adsp continues", dq_o, h(10, 1));

    ce_n = 0; ce2 = 0;
    step(1, 0, 1, 0, 1, 2'b11, 6'd12, 18'h0);
    chk("R5 deselect bus off", dq_oe, 0);
    step(1, 1, 0, 0, 1, 2'b11, '0, 18'h0);
    ce2 = 1; ce2_n = 1;
    step(0, 1, 1, 1, 1, 2'b11, 6'd13, '0);
    chk("R5 adsp deselect bus off", dq_oe, 0);
    ce2_n = 0;
    rd1("R5 no write on deselect", 12, h(12, 1));
    rd1("R5 no write while idle", 13, h(13, 1));

    oe_n = 1; #1;
    chk("R10 oe async off", dq_oe, 0);
    oe_n = 0; #1;
    chk("R10 oe async on", dq_oe, 1);

    zz = 1; #1;
    chk("R11 snooze bus off", dq_oe, 0);
    step(1, 0, 0, 0, 1, 2'b11, 6'd20, 18'h0);
    zz = 0; #1;
    chk("R11 state held", dq_o, h(13, 1));
    chk("R11 bus back", dq_oe, 1);
    rd1("R11 no write in snooze", 20, h(20, 1));

    finish_run();
  end
endmodule